// File: doc/BRIEF.md
# Saturating Float-to-Byte Converter

This block turns a 32-bit single-precision word into an 8-bit duty code for a pulse-width stage. The code lives in the top eight fraction bits of values between 1.0 and just under 2.0. In that window the exponent is fixed, so converting is mostly a matter of picking out bits. Values outside the window are not wrapped. They are clamped to the nearest end of the code range, and a flag marks that the clamp happened. This keeps a control loop whose result overshoots from flipping its drive.

The input is a word with a valid strobe. The output is a registered code byte with its own valid flag and a saturation flag. The output appears one clock after the input. The code and the flag keep their last value while no new input arrives.

Top module: `f2b_sat_conv`

## Requirements
- R1: The input word is laid out as follows: bit 31 is the sign, bits 30:23 are the biased exponent (bias 127), and bits 22:0 are the fraction. When the sign is 0 and the exponent equals 127, the code is bits 22:15 and the saturation flag is 0. For example, 0x3F800000 gives 0x00 and 0x3FFF8000 gives 0xFF.
- R2: Fraction bits 14:0 are truncated and never round the code. For example, 0x3F807FFF gives 0x00, 0x3F80FFFF gives 0x01 and 0x3FFFFFFF gives 0xFF, each without saturation.
- R3: Any word with the sign bit set gives code 0x00 with the saturation flag set. This includes negative zero and negative NaN.
- R4: A positive word with an exponent below 127 gives code 0x00 with the saturation flag set. This includes +0.0 and denormals.
- R5: A positive word with an exponent above 127 gives code 0xFF with the saturation flag set. This includes 2.0, infinity and NaN.
- R6: The output valid flag is high in exactly the cycle after the one in which the input valid is high.
- R7: While the input valid is low, the code and the saturation flag keep their values, whatever the input word is.
- R8: While reset is asserted, and after it is released until the first valid input, the output valid, code and saturation flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input word valid strobe |
| in_word | input | 32 | Single-precision input word |
| out_vld | output | 1 | Code valid, one cycle after in_vld |
| out_code | output | 8 | Duty code, clamped |
| out_sat | output | 1 | Set when out_code came from a clamp |

## Verification
The bench aims at the edges of the window on both sides: exactly 1.0, the largest in-range code, the value just below 1.0, exactly 2.0, and the special encodings of zero, infinity and NaN with either sign. A design that rounds instead of truncating would turn 0x3F80FFFF into 0x02, or overflow 0x3FFFFFFF into a wrong code. A design that ignored the sign would drive negative values to a mid-range code. A design that compared the exponent off by one would either clamp 1.0 or pass 2.0 through as 0x00. Back-to-back inputs, idle cycles with changing input words, and a reset in the middle of a run check that the code is held and that valid is aligned to the one-cycle latency.

// File: rtl/f2b_pkg.sv
package f2b_pkg;

   // Outcome of placing the input against the usable window.
   typedef enum logic [1:0] {
      RNG_IN   = 2'd0,
      RNG_LOW  = 2'd1,
      RNG_HIGH = 2'd2
   } rng_e;

endpackage

// File: rtl/f2b_unpack.sv
module f2b_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int OUT_W  = 8
) (
   input  logic [EXP_W+FRAC_W:0] word,
   output logic                  sign,
   output logic [EXP_W-1:0]      expo,
   output logic [OUT_W-1:0]      top
);

   localparam int SIGN_POS = EXP_W + FRAC_W;
   localparam int DROP_W   = FRAC_W - OUT_W;

   if (OUT_W > FRAC_W) begin : g_bad_width
      $error("f2b_unpack: OUT_W must not exceed FRAC_W");
   end

   assign sign = word[SIGN_POS];
   assign expo = word[SIGN_POS-1 -: EXP_W];

   if (DROP_W == 0) begin : g_full
      assign top = word[FRAC_W-1:0];
   end else begin : g_trunc
      // Low fraction bits below the code are discarded, no rounding.
      assign top = word[FRAC_W-1 -: OUT_W];
   end

endmodule

// File: rtl/f2b_classify.sv
module f2b_classify
   import f2b_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int BIAS  = 127
) (
   input  logic             sign,
   input  logic [EXP_W-1:0] expo,
   output rng_e             rng
);

   localparam logic [EXP_W-1:0] UNIT_EXP = EXP_W'(BIAS);

   if (BIAS <= 0 || BIAS >= (1 << EXP_W) - 1) begin : g_bad_bias
      $error("f2b_classify: BIAS out of exponent range");
   end

   always_comb begin
      if (sign) begin
         rng = RNG_LOW;
      end else if (expo < UNIT_EXP) begin
         rng = RNG_LOW;
      end else if (expo > UNIT_EXP) begin
         rng = RNG_HIGH;
      end else begin
         rng = RNG_IN;
      end
   end

endmodule

// File: rtl/f2b_clamp.sv
module f2b_clamp
   import f2b_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  rng_e             rng,
   input  logic [OUT_W-1:0] top,
   output logic [OUT_W-1:0] code,
   output logic             sat
);

   localparam logic [OUT_W-1:0] CODE_MIN = '0;
   localparam logic [OUT_W-1:0] CODE_MAX = '1;

   always_comb begin
      unique case (rng)
         RNG_LOW: begin
            code = CODE_MIN;
            sat  = 1'b1;
         end
         RNG_HIGH: begin
            code = CODE_MAX;
            sat  = 1'b1;
         end
         default: begin
            code = top;
            sat  = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/f2b_sat_conv.sv
module f2b_sat_conv
   import f2b_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int OUT_W  = 8,
   parameter int BIAS   = 127
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_vld,
   input  logic [EXP_W+FRAC_W:0]  in_word,
   output logic                   out_vld,
   output logic [OUT_W-1:0]       out_code,
   output logic                   out_sat
);

   if (EXP_W < 2 || FRAC_W < 1 || OUT_W < 1) begin : g_bad_cfg
      $error("f2b_sat_conv: field widths too small");
   end

   logic             w_sign;
   logic [EXP_W-1:0] w_expo;
   logic [OUT_W-1:0] w_top;
   rng_e             w_rng;
   logic [OUT_W-1:0] w_code;
   logic             w_sat;

   f2b_unpack #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W),
      .OUT_W  (OUT_W)
   ) u_unpack (
      .word (in_word),
      .sign (w_sign),
      .expo (w_expo),
      .top  (w_top)
   );

   f2b_classify #(
      .EXP_W (EXP_W),
      .BIAS  (BIAS)
   ) u_classify (
      .sign (w_sign),
      .expo (w_expo),
      .rng  (w_rng)
   );

   f2b_clamp #(
      .OUT_W (OUT_W)
   ) u_clamp (
      .rng  (w_rng),
      .top  (w_top),
      .code (w_code),
      .sat  (w_sat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_code <= '0;
         out_sat  <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_code <= w_code;
            out_sat  <= w_sat;
         end
      end
   end

endmodule

// File: rtl/f2b_sat_conv_chk.sv
module f2b_sat_conv_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int OUT_W  = 8,
   parameter int BIAS   = 127
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_vld,
   input logic [EXP_W+FRAC_W:0] in_word,
   input logic                  out_vld,
   input logic [OUT_W-1:0]      out_code,
   input logic                  out_sat
);

   localparam int SIGN_POS = EXP_W + FRAC_W;
   localparam logic [EXP_W-1:0] UNIT_EXP = EXP_W'(BIAS);

   logic             c_sign;
   logic [EXP_W-1:0] c_expo;
   logic [OUT_W-1:0] c_top;

   assign c_sign = in_word[SIGN_POS];
   assign c_expo = in_word[SIGN_POS-1 -: EXP_W];
   assign c_top  = in_word[FRAC_W-1 -: OUT_W];

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !c_sign && c_expo == UNIT_EXP) |=> (out_code == $past(c_top) && !out_sat)); // R1
   AST_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && c_sign) |=> (out_code == '0 && out_sat)); // R3
   AST_UNDER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !c_sign && c_expo < UNIT_EXP) |=> (out_code == '0 && out_sat)); // R4
   AST_OVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !c_sign && c_expo > UNIT_EXP) |=> (out_code == '1 && out_sat)); // R5
   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R6
   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld); // R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(out_code) && $stable(out_sat))); // R7

endmodule

bind f2b_sat_conv f2b_sat_conv_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W),
   .OUT_W  (OUT_W),
   .BIAS   (BIAS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_word  (in_word),
   .out_vld  (out_vld),
   .out_code (out_code),
   .out_sat  (out_sat)
);

// File: tb/tb_f2b_sat_conv.sv
module tb_f2b_sat_conv;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_vld;
   logic [7:0]  out_code;
   logic        out_sat;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   f2b_sat_conv dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .in_word  (in_word),
      .out_vld  (out_vld),
      .out_code (out_code),
      .out_sat  (out_sat)
   );

   // {word, code, sat}
   localparam int NV = 18;
   localparam logic [40:0] VEC [NV] = '{
      {32'h3F800000, 8'h00, 1'b0},   // R1 exactly 1.0
      {32'h3FFF8000, 8'hFF, 1'b0},   // R1 top code
      {32'h3FAA8000, 8'h55, 1'b0},   // R1
      {32'h3FD50000, 8'hAA, 1'b0},   // R1
      {32'h3F807FFF, 8'h00, 1'b0},   // R2 truncation
      {32'h3FFFFFFF, 8'hFF, 1'b0},   // R2
      {32'h3F80FFFF, 8'h01, 1'b0},   // R2
      {32'hBF800000, 8'h00, 1'b1},   // R3 -1.0
      {32'h80000000, 8'h00, 1'b1},   // R3 -0.0
      {32'hFFC00000, 8'h00, 1'b1},   // R3 negative NaN
      {32'hBFFF8000, 8'h00, 1'b1},   // R3
      {32'h00000000, 8'h00, 1'b1},   // R4 +0.0
      {32'h3F7FFFFF, 8'h00, 1'b1},   // R4 just below 1.0
      {32'h00000001, 8'h00, 1'b1},   // R4 denormal
      {32'h40000000, 8'hFF, 1'b1},   // R5 2.0
      {32'h7F800000, 8'hFF, 1'b1},   // R5 +inf
      {32'h7FC00000, 8'hFF, 1'b1},   // R5 NaN
      {32'h4B000000, 8'hFF, 1'b1}    // R5 large
   };
   localparam int VREQ [NV] = '{1,1,1,1,2,2,2,3,3,3,3,4,4,4,5,5,5,5};

   task automatic chk(input int req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Drive one valid word, then sample after the capturing edge.
   task automatic push(input logic [31:0] w);
      @(negedge clk);
      in_vld  = 1'b1;
      in_word = w;
      @(negedge clk);
      in_vld  = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(8, "vld in reset", 32'(out_vld), 0);     // R8
      chk(8, "code in reset", 32'(out_code), 0);   // R8
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(8, "vld after reset", 32'(out_vld), 0);  // R8
      chk(8, "sat after reset", 32'(out_sat), 0);  // R8

      for (int i = 0; i < NV; i++) begin
         push(VEC[i][40:9]);
         chk(VREQ[i], "code", 32'(out_code), 32'(VEC[i][8:1]));
         chk(VREQ[i], "sat", 32'(out_sat), 32'(VEC[i][0]));
         chk(6, "vld", 32'(out_vld), 1);           // R6
      end

      // R6: valid drops one cycle after input valid drops
      @(negedge clk);
      chk(6, "vld idle", 32'(out_vld), 0);

      // R7: hold while idle with changing word
      push(32'h3FAA8000);
      for (int k = 0; k < 4; k++) begin
         in_word = (k[0]) ? 32'h40000000 : 32'hBF800000;
         @(negedge clk);
         chk(7, "hold code", 32'(out_code), 32'h55);
         chk(7, "hold sat", 32'(out_sat), 0);
         chk(6, "vld low idle", 32'(out_vld), 0);
      end

      // R6: back-to-back valid words
      @(negedge clk);
      in_vld = 1'b1; in_word = 32'h3FD50000;
      @(negedge clk);
      chk(6, "b2b first code", 32'(out_code), 32'hAA);
      chk(6, "b2b first vld", 32'(out_vld), 1);
      in_word = 32'h7F800000;
      @(negedge clk);
      in_vld = 1'b0;
      chk(5, "b2b second code", 32'(out_code), 32'hFF);
      chk(5, "b2b second sat", 32'(out_sat), 1);

      // R8: reset mid-run clears everything
      push(32'h40000000);
      rst_n = 1'b0;
      #1;
      chk(8, "mid reset vld", 32'(out_vld), 0);
      chk(8, "mid reset code", 32'(out_code), 0);
      chk(8, "mid reset sat", 32'(out_sat), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(8, "post reset code", 32'(out_code), 0);

      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule